// File: doc/BRIEF.md
# Lockable Software Watchdog Timer

This block is a down-counting watchdog. Software keeps the system alive by periodically writing a two-word key pair to a service port. If no completed pair arrives before the count runs out, the block responds in one of two ways. It either raises a system reset request for a fixed number of cycles, or it raises a non-maskable interrupt that stays up until the next completed service.

A single protection configuration word sets the behaviour. It holds an enable bit, the response choice and a timeout select. On leaving reset, the watchdog is already armed at its longest timeout with the reset response. Software gets one configuration write after each reset. It can use that write to shorten the timeout, to switch to the interrupt response, or to turn the watchdog off. The write then locks the word until the next reset, and a status output reports the lock.

The timeout for select value s is 2^(MIN_LOG2 + STEP_LOG2*s) clock cycles. The defaults give 16, 64, 256 and 1024 cycles. The reset request lasts RST_LEN cycles, 4 by default.

Top module: `lockwd_top`

## Requirements
- R1: After reset, rst_req, nmi and cfg_locked are 0. The watchdog is enabled with timeout select 3 and the reset response, so with no service rst_req rises 1024 cycles (default parameters) after the last reset edge.
- R2: An expiry occurs exactly T cycles after the most recent reload. T = 2^(MIN_LOG2 + STEP_LOG2*s) and s is the active timeout select. Expiry repeats every T cycles while no service arrives.
- R3: With the reset response, an expiry drives rst_req high for exactly RST_LEN consecutive cycles.
- R4: With the interrupt response, an expiry sets nmi. It stays high, across further expiries, until a completed service clears it.
- R5: Configuration word layout: bit 0 = enable, bit 1 = response (0 = reset request, 1 = interrupt), bits [3:2] = timeout select. A write that takes effect also reloads the counter with the new timeout.
- R6: Only the first configuration write after reset takes effect, and it sets cfg_locked. Later writes do not change the enable, response or timeout, and they do not reload the counter.
- R7: While disabled, the watchdog never expires. rst_req and nmi stay low.
- R8: A service is completed only when a write of KEY_A (default 16'hC3A5) is followed by a write of KEY_B (default 16'h5A3C) as the next service-port write. Idle cycles may separate the two writes. A completed service reloads the counter and clears nmi. A KEY_B write that does not directly follow KEY_A does nothing.
- R9: Reset clears the lock and nmi and restores the power-on configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration word (enable, response, timeout select) |
| svc_we | input | 1 | Service write strobe |
| svc_data | input | KEY_W (16) | Service key value |
| rst_req | output | 1 | System reset request pulse |
| nmi | output | 1 | Non-maskable interrupt, held until serviced |
| cfg_locked | output | 1 | High once the configuration word has been written |

## Verification
The assertions check on every cycle that the lock never drops and freezes the configuration. They also check that an interrupt stays up until a completed service and is cleared by it, that each reset request lasts exactly the pulse length, and that an interrupt can only rise while the watchdog is enabled. The bench scenarios show the behaviours that depend on exact expiry timing. These are the cycle counts for each timeout select, the effect of a well-placed service on the next expiry, and the rejection of malformed key sequences. The bench also shows that a late configuration write neither disables nor reloads the counter, and that a disabled watchdog stays silent past the longest timeout.

// File: rtl/lockwd_pkg.sv
package lockwd_pkg;
  localparam int TSEL_W = 2;
  localparam int CFG_W  = TSEL_W + 2;

  typedef struct packed {
    logic [TSEL_W-1:0] tsel;
    logic              nmi_mode;
    logic              en;
  } cfg_t;

  // Power-on: longest timeout, reset response, enabled.
  localparam cfg_t CFG_RESET = cfg_t'({{TSEL_W{1'b1}}, 1'b0, 1'b1});
endpackage

// File: rtl/lockwd_cfg.sv
module lockwd_cfg
  import lockwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg,
  output logic             apply,
  output logic             locked
);
  assign apply = we & ~locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= CFG_RESET;
      locked <= 1'b0;
    end else if (apply) begin
      cfg    <= cfg_t'(wdata);
      locked <= 1'b1;
    end
  end

  // R6: once locked, the word stays locked until reset.
  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  // R6: a locked word never changes.
  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(cfg));
endmodule

// File: rtl/lockwd_key.sv
module lockwd_key #(
  parameter int              KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY_A = 16'hC3A5,
  parameter logic [KEY_W-1:0] KEY_B = 16'h5A3C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [KEY_W-1:0] data,
  output logic             svc_ok
);
  logic armed;

  // Any service write re-evaluates the arm state; only KEY_A arms.
  always_ff @(posedge clk) begin
    if (rst)     armed <= 1'b0;
    else if (we) armed <= (data == KEY_A);
  end

  assign svc_ok = we & armed & (data == KEY_B);

  // R8: completing a pair consumes the arm state.
  p_pair_consumed_r8: assert property (@(posedge clk) disable iff (rst)
    svc_ok |=> !armed);
endmodule

// File: rtl/lockwd_timer.sv
module lockwd_timer #(
  parameter int MIN_LOG2  = 4,
  parameter int STEP_LOG2 = 2,
  parameter int TSEL_W    = 2,
  parameter int RST_LEN   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              nmi_mode,
  input  logic [TSEL_W-1:0] tsel_ld,
  input  logic              reload,
  input  logic              svc,
  output logic              rst_req,
  output logic              nmi
);
  localparam int NSEL  = 2 ** TSEL_W;
  localparam int CNT_W = MIN_LOG2 + STEP_LOG2 * (NSEL - 1);
  localparam int PW    = $clog2(RST_LEN + 1);
  localparam logic [CNT_W-1:0] MAX_LD = '1;

  logic [CNT_W-1:0] ld_tab [NSEL];
  for (genvar g = 0; g < NSEL; g++) begin : g_ld
    localparam int LG = MIN_LOG2 + STEP_LOG2 * g;
    assign ld_tab[g] = CNT_W'((64'd1 << LG) - 64'd1);
  end

  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    pcnt;
  logic             nmi_q;
  logic             expire;

  assign expire = en & (cnt == '0) & ~reload;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= MAX_LD;
    end else if (reload) begin
      cnt <= ld_tab[tsel_ld];
    end else if (en) begin
      cnt <= (cnt == '0) ? ld_tab[tsel_ld] : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        pcnt <= '0;
    else if (expire && !nmi_mode)   pcnt <= PW'(RST_LEN);
    else if (pcnt != '0)            pcnt <= pcnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                      nmi_q <= 1'b0;
    else if (svc)                 nmi_q <= 1'b0;
    else if (expire && nmi_mode)  nmi_q <= 1'b1;
  end

  assign rst_req = (pcnt != '0);
  assign nmi     = nmi_q;

  // Checker: length of the current reset-request run.
  logic [PW:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst)          hi_run <= '0;
    else if (rst_req) hi_run <= hi_run + 1'b1;
    else              hi_run <= '0;
  end

  // R3: the request never exceeds its length and always reaches it.
  p_pulse_max_r3: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (hi_run < (PW+1)'(RST_LEN)));
  p_pulse_full_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_req) |-> (hi_run == (PW+1)'(RST_LEN)));

  // R4: the interrupt holds until a completed service.
  p_nmi_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (nmi && !svc) |=> nmi);

  // R8: a completed service drops the interrupt.
  p_svc_clear_r8: assert property (@(posedge clk) disable iff (rst)
    svc |=> !nmi);
endmodule

// File: rtl/lockwd_top.sv
module lockwd_top
  import lockwd_pkg::*;
#(
  parameter int               MIN_LOG2  = 4,
  parameter int               STEP_LOG2 = 2,
  parameter int               RST_LEN   = 4,
  parameter int               KEY_W     = 16,
  parameter logic [KEY_W-1:0] KEY_A     = 16'hC3A5,
  parameter logic [KEY_W-1:0] KEY_B     = 16'h5A3C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             svc_we,
  input  logic [KEY_W-1:0] svc_data,
  output logic             rst_req,
  output logic             nmi,
  output logic             cfg_locked
);
  cfg_t              cfg_q;
  logic              cfg_apply;
  logic              svc_ok;
  logic [TSEL_W-1:0] ld_tsel;

  lockwd_cfg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .cfg    (cfg_q),
    .apply  (cfg_apply),
    .locked (cfg_locked)
  );

  lockwd_key #(.KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk    (clk),
    .rst    (rst),
    .we     (svc_we),
    .data   (svc_data),
    .svc_ok (svc_ok)
  );

  // A taking write loads its own timeout; otherwise the active one.
  assign ld_tsel = cfg_apply ? cfg_wdata[CFG_W-1 -: TSEL_W] : cfg_q.tsel;

  lockwd_timer #(
    .MIN_LOG2  (MIN_LOG2),
    .STEP_LOG2 (STEP_LOG2),
    .TSEL_W    (TSEL_W),
    .RST_LEN   (RST_LEN)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .en       (cfg_q.en),
    .nmi_mode (cfg_q.nmi_mode),
    .tsel_ld  (ld_tsel),
    .reload   (cfg_apply | svc_ok),
    .svc      (svc_ok),
    .rst_req  (rst_req),
    .nmi      (nmi)
  );

  // R7: an interrupt can only rise out of an enabled cycle.
  p_nmi_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi) |-> $past(cfg_q.en));
endmodule

// File: tb/lockwd_top_bench.sv
module lockwd_top_bench;
  localparam logic [15:0] KA = 16'hC3A5;
  localparam logic [15:0] KB = 16'h5A3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic        svc_we = 1'b0;
  logic [15:0] svc_data = '0;
  logic        rst_req, nmi, cfg_locked;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int    at;
    logic  r;
    logic  n;
    logic  l;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lockwd_top u_lockwd_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .svc_we(svc_we), .svc_data(svc_data),
    .rst_req(rst_req), .nmi(nmi), .cfg_locked(cfg_locked)
  );

  // Monitor: pops expected items as their cycle arrives.
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].at <= cyc) begin
      e = q.pop_front();
      checks++;
      if (rst_req !== e.r || nmi !== e.n || cfg_locked !== e.l) begin
        errors++;
        $display("FAIL %s at cycle %0d: rst_req=%0b nmi=%0b locked=%0b expected %0b %0b %0b",
                 e.tag, cyc, rst_req, nmi, cfg_locked, e.r, e.n, e.l);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_in(input int k, input logic r, input logic n,
                           input logic l, input string tag);
    exp_t e;
    e.at = cyc + k; e.r = r; e.n = n; e.l = l; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(3); rst = 1'b0;
  endtask

  task automatic do_cfg(input logic [3:0] v);
    cfg_we = 1'b1; cfg_wdata = v; tick(1); cfg_we = 1'b0;
  endtask

  task automatic svc(input logic [15:0] d);
    svc_we = 1'b1; svc_data = d; tick(1); svc_we = 1'b0;
  endtask

  initial begin
    tick(1);
    // R1: power-on state and default expiry with reset response.
    do_reset();
    expect_in(1,    0, 0, 0, "R1 reset state");
    expect_in(1023, 0, 0, 0, "R1 no expiry before 1024");
    expect_in(1024, 1, 0, 0, "R1 default expiry");
    expect_in(1027, 1, 0, 0, "R3 pulse still high");
    expect_in(1028, 0, 0, 0, "R3 pulse length");
    tick(1030);

    // R5/R2/R4: interrupt response, select 0 (16 cycles).
    do_reset();
    do_cfg(4'b0011);
    expect_in(15, 0, 0, 1, "R2 no expiry at 15");
    expect_in(16, 0, 1, 1, "R5 nmi response at 16");
    expect_in(40, 0, 1, 1, "R4 nmi held");
    tick(41);
    svc(KB);
    expect_in(1, 0, 1, 1, "R8 lone second key ignored");
    tick(2);
    svc(KA); svc(16'h1234); svc(KB);
    expect_in(1, 0, 1, 1, "R8 broken pair ignored");
    tick(2);
    svc(KA); tick(3); svc(KB);
    expect_in(1,  0, 0, 1, "R8 pair clears nmi");
    expect_in(15, 0, 0, 1, "R2 reload timing 15");
    expect_in(16, 0, 1, 1, "R2 reload timing 16");
    tick(20);

    // R6: second write (disable) ignored, no reload.
    svc(KA); svc(KB);
    do_cfg(4'b0000);
    expect_in(1,  0, 0, 1, "R6 locked after write");
    expect_in(14, 0, 0, 1, "R6 no reload from late write");
    expect_in(15, 0, 1, 1, "R6 late disable ignored");
    tick(20);

    // R9 and R7: reset unlocks; disabled watchdog stays quiet.
    do_reset();
    expect_in(1, 0, 0, 0, "R9 reset clears lock and nmi");
    tick(2);
    do_cfg(4'b0000);
    expect_in(1100, 0, 0, 1, "R7 disabled no expiry");
    expect_in(2100, 0, 0, 1, "R7 disabled long wait");
    tick(2101);

    // R5/R3/R8: select 1 (64 cycles), reset response, service delays.
    do_reset();
    do_cfg(4'b0101);
    expect_in(63, 0, 0, 1, "R5 select 1 no expiry at 63");
    expect_in(64, 1, 0, 1, "R5 select 1 expiry at 64");
    expect_in(67, 1, 0, 1, "R3 pulse high");
    expect_in(68, 0, 0, 1, "R3 pulse ends");
    tick(98);
    svc(KA); svc(KB);
    expect_in(28, 0, 0, 1, "R8 service postpones expiry");
    expect_in(63, 0, 0, 1, "R8 new window 63");
    expect_in(64, 1, 0, 1, "R8 expiry after service");
    tick(70);

    // R2: select 2 (256 cycles) with interrupt.
    do_reset();
    do_cfg(4'b1011);
    expect_in(255, 0, 0, 1, "R2 select 2 at 255");
    expect_in(256, 0, 1, 1, "R2 select 2 at 256");
    tick(260);

    tick(2);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 pending expectations: %0d left, expected 0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog expired: cycle %0d expected finish before 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule